// File: doc/BRIEF.md
# Dual-Rail Return-to-Spacer Link

This block carries an N-bit word across a delay-insensitive channel. Each bit travels on a true rail and a false rail. The transmitter takes a word through a valid/ready handshake and raises exactly one rail per bit. The receiver watches the rail pairs and decides for itself when the word has fully arrived. It needs no strobe and no shared clock edge: a word counts as present only once every pair has left the empty state. The receiver then latches the word, pulses a strobe and raises an acknowledge. The transmitter answers by clearing every rail. The receiver drops its acknowledge once it has seen every pair empty, and only then may the transmitter offer the next word.

Both ends are clocked logic that samples the other side through two-flop synchronizers. They can therefore sit in unrelated clock domains, or be looped back on one clock for testing. A pair with both rails high is not a legal code. The receiver reports it and never accepts a word that contains one.

Top module: `dr4_link`

## Requirements
- R1: While reset is asserted and directly after it, every transmit rail is low, `in_ready` is high, and `rx_ack`, `rx_strobe` and `rx_err` are low.
- R2: A word accepted on `in_valid && in_ready` at a clock edge appears on the rails after that edge. Bit value 1 drives `tx_rail_t` high and `tx_rail_f` low, bit value 0 drives `tx_rail_f` high and `tx_rail_t` low, and the transmitter never drives both rails of a pair high.
- R3: `in_ready` is high only while the transmitter is empty (all rails low) and its synchronized acknowledge is low. While a code is out and the acknowledge has not arrived, the rails hold their value.
- R4: Once `tx_ack` goes high, all transmit rails return low on the third clock edge, and not before.
- R5: After the rails return low, the transmitter offers no new word while `tx_ack` stays high, even when `in_valid` is held high.
- R6: `rx_ack` rises only after every receive pair holds a valid code (true-only or false-only). A word with even one pair still empty raises no acknowledge.
- R7: When a complete word is taken, `rx_data` presents the true rails as the word and `rx_strobe` is high for exactly the one cycle in which `rx_ack` rises. This happens three clock edges after the last pair becomes valid at the input.
- R8: `rx_ack` falls only after every receive pair is back at both-low. A partial return keeps it high.
- R9: A receive pair with both rails high sets `rx_err` for every cycle in which the synchronized rails show it. A word holding such a pair is never accepted.
- R10: With the transmit rails looped to the receive rails and `rx_ack` looped to `tx_ack`, words sent back to back arrive in order and unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | W | Word offered to the transmitter |
| in_valid | input | 1 | Word offer |
| in_ready | output | 1 | Transmitter can take a word |
| tx_rail_t | output | W | Transmit true rails |
| tx_rail_f | output | W | Transmit false rails |
| tx_ack | input | 1 | Acknowledge from the far receiver |
| rx_rail_t | input | W | Receive true rails |
| rx_rail_f | input | W | Receive false rails |
| rx_ack | output | 1 | Acknowledge to the far transmitter |
| rx_data | output | W | Last word received |
| rx_strobe | output | 1 | One-cycle pulse when a word is taken |
| rx_err | output | 1 | A both-high pair is visible |

## Verification
Completion and error detection can meet in one cycle. A word can show every pair but one valid while that last pair is both-high, so the completion count looks nearly full just as the illegal pair appears. The bench provokes this by driving such a word straight onto the receive rails. It judges the result by requiring `rx_err` high with no strobe and no acknowledge, and then a clean word accepted afterwards. A second meeting point is a new offer on `in_valid` that arrives while the acknowledge is still high. It is held there for several cycles, and the rails must stay empty until the synchronized acknowledge has fallen.

// File: rtl/dr4_link.sv
module dr4_link #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic         in_ready,
  output logic [W-1:0] tx_rail_t,
  output logic [W-1:0] tx_rail_f,
  input  logic         tx_ack,
  input  logic [W-1:0] rx_rail_t,
  input  logic [W-1:0] rx_rail_f,
  output logic         rx_ack,
  output logic [W-1:0] rx_data,
  output logic         rx_strobe,
  output logic         rx_err
);

  typedef enum logic [1:0] {TX_IDLE, TX_DATA, TX_RTZ} tx_st_e;

  tx_st_e tx_st;
  logic   ack_s1, ack_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= tx_ack;
      ack_s2 <= ack_s1;
    end
  end

  assign in_ready = (tx_st == TX_IDLE) && !ack_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_st     <= TX_IDLE;
      tx_rail_t <= '0;
      tx_rail_f <= '0;
    end else begin
      case (tx_st)
        TX_IDLE: if (in_valid && !ack_s2) begin
          tx_rail_t <= in_data;
          tx_rail_f <= ~in_data;
          tx_st     <= TX_DATA;
        end
        TX_DATA: if (ack_s2) begin
          tx_rail_t <= '0;
          tx_rail_f <= '0;
          tx_st     <= TX_RTZ;
        end
        TX_RTZ: if (!ack_s2) tx_st <= TX_IDLE;
        default: tx_st <= TX_IDLE;
      endcase
    end
  end

  AST_TX_NO_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rail_t & tx_rail_f) == '0); // R2
  AST_READY_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> ((tx_rail_t | tx_rail_f) == '0)); // R3
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_st == TX_DATA && !ack_s2) |=> ($stable(tx_rail_t) && $stable(tx_rail_f))); // R3
  AST_CLEAR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_st == TX_DATA && ack_s2) |=> ((tx_rail_t | tx_rail_f) == '0)); // R4
  AST_START_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|(tx_rail_t | tx_rail_f)) |-> !$past(ack_s2)); // R5

  logic [W-1:0] rt1, rf1, rt2, rf2;
  logic         all_valid, any_bad, all_spacer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt1 <= '0;
      rf1 <= '0;
      rt2 <= '0;
      rf2 <= '0;
    end else begin
      rt1 <= rx_rail_t;
      rf1 <= rx_rail_f;
      rt2 <= rt1;
      rf2 <= rf1;
    end
  end

  assign all_valid  = &(rt2 ^ rf2);
  assign any_bad    = |(rt2 & rf2);
  assign all_spacer = ~|(rt2 | rf2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ack    <= 1'b0;
      rx_data   <= '0;
      rx_strobe <= 1'b0;
      rx_err    <= 1'b0;
    end else begin
      rx_err    <= any_bad;
      rx_strobe <= 1'b0;
      if (!rx_ack) begin
        if (all_valid) begin
          rx_ack    <= 1'b1;
          rx_data   <= rt2;
          rx_strobe <= 1'b1;
        end
      end else if (all_spacer) begin
        rx_ack <= 1'b0;
      end
    end
  end

  AST_ACK_RISE_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ack) |-> $past(all_valid)); // R6
  AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> $rose(rx_ack)); // R7
  AST_ACK_FALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ack) |-> $past(all_spacer)); // R8
  AST_ERR_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> !rx_strobe); // R9

endmodule

// File: tb/dr4_link_tb.sv
module dr4_link_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] in_data = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] tx_t, tx_f, rx_data;
  logic         rx_ack, rx_strobe, rx_err;
  logic         loop = 1'b1;
  logic [W-1:0] drv_t = '0, drv_f = '0;
  logic         drv_ack = 1'b0;
  wire  [W-1:0] rx_t_w = loop ? tx_t : drv_t;
  wire  [W-1:0] rx_f_w = loop ? tx_f : drv_f;
  wire          ack_w  = loop ? rx_ack : drv_ack;

  dr4_link #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .tx_rail_t(tx_t), .tx_rail_f(tx_f), .tx_ack(ack_w),
    .rx_rail_t(rx_t_w), .rx_rail_f(rx_f_w), .rx_ack(rx_ack),
    .rx_data(rx_data), .rx_strobe(rx_strobe), .rx_err(rx_err));

  int checks = 0;
  int fails = 0;
  logic [W-1:0] sent_q[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase numbers and delay lines, compared every clock
  int           m_phase;
  bit [1:0]     m_ackd;
  logic [W-1:0] m_tt, m_tf, m_d1t, m_d1f, m_d2t, m_d2f, m_data;
  bit           m_ack, m_stb, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0; m_ackd <= 0; m_tt <= '0; m_tf <= '0;
      m_d1t <= '0; m_d1f <= '0; m_d2t <= '0; m_d2f <= '0;
      m_data <= '0; m_ack <= 0; m_stb <= 0; m_err <= 0;
    end else begin
      int nval, nemp, nbad;
      nval = 0; nemp = 0; nbad = 0;
      for (int i = 0; i < W; i++) begin
        if (m_d2t[i] && m_d2f[i]) nbad++;
        else if (!m_d2t[i] && !m_d2f[i]) nemp++;
        else nval++;
      end
      m_ackd <= {m_ackd[0], ack_w};
      if (m_phase == 0 && in_valid && !m_ackd[1]) begin
        for (int i = 0; i < W; i++) begin
          m_tt[i] <= in_data[i];
          m_tf[i] <= !in_data[i];
        end
        m_phase <= 1;
      end else if (m_phase == 1 && m_ackd[1]) begin
        m_tt <= '0; m_tf <= '0; m_phase <= 2;
      end else if (m_phase == 2 && !m_ackd[1]) begin
        m_phase <= 0;
      end
      m_d1t <= rx_t_w; m_d1f <= rx_f_w; m_d2t <= m_d1t; m_d2f <= m_d1f;
      m_err <= (nbad > 0);
      m_stb <= 0;
      if (!m_ack && nval == W) begin
        m_ack <= 1; m_data <= m_d2t; m_stb <= 1;
      end else if (m_ack && nemp == W) begin
        m_ack <= 0;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(tx_t == m_tt && tx_f == m_tf, "R2 rails vs model", {tx_t, tx_f}, {m_tt, m_tf});
    chk(in_ready == (m_phase == 0 && !m_ackd[1]), "R3 ready vs model", in_ready, (m_phase == 0 && !m_ackd[1]));
    chk(rx_ack == m_ack, "R6 rx_ack vs model", rx_ack, m_ack);
    chk(rx_data == m_data && rx_strobe == m_stb, "R7 data/strobe vs model", {rx_data, rx_strobe}, {m_data, m_stb});
    chk(rx_err == m_err, "R9 rx_err vs model", rx_err, m_err);
    if (loop && rx_strobe) begin
      if (sent_q.size() == 0) chk(0, "R10 unexpected word", rx_data, 0);
      else begin
        logic [W-1:0] e;
        e = sent_q.pop_front();
        chk(rx_data == e, "R10 loopback order", rx_data, e);
      end
    end
  end

  task automatic send(input logic [W-1:0] d);
    @(negedge clk);
    in_data = d; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (loop) sent_q.push_back(d);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      fails++;
      $display("FAIL watchdog R10 act=%0d exp=%0d", wd, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w;
    wait_n(2);
    chk(tx_t == '0 && tx_f == '0, "R1 rails empty in reset", {tx_t, tx_f}, 0);
    chk(in_ready && !rx_ack && !rx_strobe && !rx_err, "R1 outputs in reset",
        {in_ready, rx_ack, rx_strobe, rx_err}, 4'b1000);
    rst_n = 1'b1;
    wait_n(1);
    chk(tx_t == '0 && tx_f == '0 && in_ready && !rx_ack, "R1 after reset",
        {tx_t, tx_f, in_ready, rx_ack}, 1);

    // R10 loopback, back to back
    foreach (w[i]) ;
    send(8'h00); send(8'hFF); send(8'hA5); send(8'h5A); send(8'h01); send(8'h80);
    for (int k = 0; k < 200 && sent_q.size() != 0; k++) @(negedge clk);
    chk(sent_q.size() == 0, "R10 all words delivered", sent_q.size(), 0);
    wait_n(12);

    // receiver driven directly
    loop = 1'b0; drv_ack = 1'b0; drv_t = '0; drv_f = '0;
    wait_n(4);
    drv_t = 8'b0101_0100; drv_f = 8'b1010_1010;   // bit0 still empty
    wait_n(8);
    chk(!rx_ack && !rx_strobe, "R6 partial word not acknowledged", rx_ack, 0);
    drv_t[0] = 1'b1;
    wait_n(2);
    chk(!rx_ack, "R7 no ack before third edge", rx_ack, 0);
    wait_n(1);
    chk(rx_ack && rx_strobe && rx_data == 8'h55, "R7 word taken with strobe",
        {rx_ack, rx_strobe, rx_data}, {2'b11, 8'h55});
    wait_n(1);
    chk(!rx_strobe && rx_ack, "R7 strobe one cycle", rx_strobe, 0);
    drv_t = 8'b0000_0000; drv_f = 8'b0000_1000;   // bit3 not returned
    wait_n(8);
    chk(rx_ack, "R8 partial return keeps ack", rx_ack, 1);
    drv_f = '0;
    wait_n(4);
    chk(!rx_ack, "R8 ack falls after full return", rx_ack, 0);
    drv_t = 8'b0011_0100; drv_f = 8'b1100_1111;   // bit2 both high, rest valid
    wait_n(5);
    chk(rx_err && !rx_ack && !rx_strobe, "R9 illegal pair flagged, not taken",
        {rx_err, rx_ack, rx_strobe}, 3'b100);
    drv_t = '0; drv_f = '0;
    wait_n(4);
    chk(!rx_err && !rx_ack, "R9 error clears when pair empties", {rx_err, rx_ack}, 0);
    drv_t = 8'h3C; drv_f = 8'hC3;
    wait_n(4);
    chk(rx_ack && rx_data == 8'h3C, "R9 clean word accepted after error", rx_data, 8'h3C);
    drv_t = '0; drv_f = '0;
    wait_n(4);

    // transmitter driven directly
    send(8'h96);
    chk(tx_t == 8'h96 && tx_f == 8'h69, "R2 rail encoding", {tx_t, tx_f}, {8'h96, 8'h69});
    chk(!in_ready, "R3 ready low while code out", in_ready, 0);
    wait_n(10);
    chk(tx_t == 8'h96 && tx_f == 8'h69, "R3 code held awaiting ack", {tx_t, tx_f}, {8'h96, 8'h69});
    drv_ack = 1'b1;
    wait_n(2);
    chk(tx_t == 8'h96, "R4 rails not cleared before third edge", tx_t, 8'h96);
    wait_n(1);
    chk(tx_t == '0 && tx_f == '0, "R4 rails cleared on third edge", {tx_t, tx_f}, 0);
    in_data = 8'h3A; in_valid = 1'b1;
    wait_n(6);
    chk(tx_t == '0 && tx_f == '0 && !in_ready, "R5 no new word while ack high",
        {tx_t, tx_f, in_ready}, 0);
    drv_ack = 1'b0;
    for (int k = 0; k < 10 && !in_ready; k++) @(negedge clk);
    chk(in_ready, "R5 ready returns after ack low", in_ready, 1);
    wait_n(1);
    in_valid = 1'b0;
    chk(tx_t == 8'h3A && tx_f == 8'hC5, "R5 next word sent after ack low", tx_t, 8'h3A);
    drv_ack = 1'b1;
    wait_n(5);
    drv_ack = 1'b0;
    wait_n(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule